// File: doc/BRIEF.md
# Paged SPI Register Access Master

This block lets on-chip logic read and write byte-addressed registers in a remote device that exposes a paged register space over a four-wire SPI link. The host side presents a page number, a register offset, an access size of one, two or four bytes, a direction and, for writes, the data. The master handles all link activity. It builds the command frames, drives chip select and the serial clock, and shifts the bits. It remembers which page it last selected in the remote device and sends a page-select frame only when the page changes.

Reads use a fast-read command. After the offset, the remote device may need some time before its data is ready. The master clocks in whole filler bytes until one has its least significant bit set, which marks the data as ready. It then collects the data bytes. If the ready marker never arrives within a bounded number of polled bytes, the access ends with an error. Each access ends with a single-cycle completion pulse. On a read, this pulse comes with the assembled data.

Top module: `spi_page_master`

## Requirements
- R1: With no frame in progress, spi_ss_n_o is 1, spi_sck_o is 0 and spi_mosi_o is 0, and after reset ready_o is 1.
- R2: Every byte goes out most significant bit first. MOSI changes only while SCK is low, so the remote device can sample it on the rising SCK edge. MISO is sampled during the low half just before each rising edge.
- R3: A write is one chip-select frame of 2+N bytes: 0x61, then the offset, then N data bytes taken from wdata_i, lowest byte first. len_i selects N: code 0 gives 1 byte, code 1 gives 2 bytes, and codes 2 and 3 give 4 bytes.
- R4: Before an access, a separate frame 0x61, 0xFF, page is sent only if the requested page differs from the last page sent. After reset no page counts as sent, so the first access always sends this frame.
- R5: A read is one frame: 0x10, then the offset, then polled bytes. Bytes with bit 0 clear are dropped. The first byte with bit 0 set is the ready marker. The next N bytes are returned in rdata_o, lowest byte first, and the unused upper bytes are zero.
- R6: If MAX_POLL polled bytes (default 100) all have bit 0 clear, the frame closes and done_o pulses with err_o = 1 and rdata_o = 0. A marker on the last allowed poll still completes normally with err_o = 0.
- R7: One time unit is CLK_DIV clock cycles. SCK stays high for exactly two units per bit and low for at least two units inside a frame. Chip select stays low for one unit before the first bit and after the last bit, and stays high for at least one unit between frames.
- R8: A request is taken only in a cycle where both req_i and ready_o are 1, and ready_o then drops until the access finishes. done_o is high for exactly one cycle per access. err_o is only ever high together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| ready_o | output | 1 | Idle; a request is taken in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| page_i | input | PW | Register page |
| offset_i | input | PW | Register offset within the page |
| len_i | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, otherwise 4 bytes |
| wdata_i | input | 32 | Write data, lowest byte sent first |
| rdata_o | output | 32 | Read data, valid while done_o is high |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Read timed out waiting for the ready marker |
| spi_ss_n_o | output | 1 | Chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to the remote device |
| spi_miso_i | input | 1 | Serial data from the remote device |

## Verification
The assertions assume that req_i is raised only when ready_o is high, or that any request made while busy is simply not taken. They also assume that the remote device changes MISO only just after a rising SCK edge, so that it is stable across the low half in which the master samples it. The bench drives every request from a task that waits for the previous done pulse, and holds req_i for one cycle only. Its model of the remote device updates MISO right after each rising SCK edge. The number of filler bytes is chosen per access, from zero up to beyond the poll limit.

// File: rtl/spi_pm_pkg.sv
package spi_pm_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD, ST_GAP} pm_state_e;

  localparam logic [7:0] CMD_WRITE     = 8'h61;
  localparam logic [7:0] CMD_FAST_READ = 8'h10;
  localparam logic [7:0] PAGE_SEL_REG  = 8'hFF;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/spi_pm_tick.sv
module spi_pm_tick #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (restart_i)      cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/spi_pm_shift.sv
module spi_pm_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  logic       busy_q;
  logic [1:0] ph_q;
  logic [2:0] bit_q;
  logic [7:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        ph_q   <= '0;
        bit_q  <= 3'd7;
        tx_q   <= tx_i;
      end else if (busy_q && tick_i) begin
        ph_q <= ph_q + 1'b1;
        // sample at the end of the low half, ahead of the rising edge
        if (ph_q == 2'd1) rx_q <= {rx_q[6:0], miso_i};
        if (ph_q == 2'd3) begin
          if (bit_q == 3'd0) begin
            busy_q <= 1'b0;
            done_o <= 1'b1;
          end else begin
            bit_q <= bit_q - 1'b1;
          end
        end
      end
    end
  end

  assign sck_o  = busy_q & ph_q[1];
  assign mosi_o = busy_q & tx_q[bit_q];
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_page_master.sv
module spi_page_master
  import spi_pm_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int MAX_POLL = 100,
  parameter int PW       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  output logic          ready_o,
  input  logic          we_i,
  input  logic [PW-1:0] page_i,
  input  logic [PW-1:0] offset_i,
  input  logic [1:0]    len_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          done_o,
  output logic          err_o,
  output logic          spi_ss_n_o,
  output logic          spi_sck_o,
  output logic          spi_mosi_o,
  input  logic          spi_miso_i
);
  localparam int PCW = $clog2(MAX_POLL + 1);
  localparam logic [PCW-1:0] POLL_LAST = PCW'(MAX_POLL - 1);

  pm_state_e     state_q, state_d;
  logic [2:0]    pos_q, tx_idx, nb_q;
  logic          frm_page_q, we_q, pvalid_q, acked_q, err_q;
  logic [PW-1:0] page_q, off_q, pcache_q;
  logic [31:0]   wdata_q, rbuf_q;
  logic [1:0]    dcnt_q, wsel;
  logic [PCW-1:0] poll_q;
  logic [7:0]    tx_byte, sh_rx;
  logic          tick, sh_start, sh_done, last_byte, restart, page_miss;

  spi_pm_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i, .rst_ni, .restart_i(restart), .tick_o(tick)
  );

  spi_pm_shift u_shift (
    .clk_i, .rst_ni, .tick_i(tick), .start_i(sh_start), .tx_i(tx_byte),
    .miso_i(spi_miso_i), .sck_o(spi_sck_o), .mosi_o(spi_mosi_o),
    .done_o(sh_done), .rx_o(sh_rx)
  );

  assign page_miss = !pvalid_q || (page_i != pcache_q);
  assign tx_idx    = (state_q == ST_SETUP) ? 3'd0 : ((pos_q == 3'd7) ? pos_q : pos_q + 3'd1);
  assign wsel      = 2'(tx_idx - 3'd2);

  always_comb begin
    tx_byte = 8'h00;
    if (frm_page_q) begin
      case (tx_idx)
        3'd0:    tx_byte = CMD_WRITE;
        3'd1:    tx_byte = PAGE_SEL_REG;
        default: tx_byte = 8'(page_q);
      endcase
    end else if (tx_idx == 3'd0) begin
      tx_byte = we_q ? CMD_WRITE : CMD_FAST_READ;
    end else if (tx_idx == 3'd1) begin
      tx_byte = 8'(off_q);
    end else if (we_q) begin
      tx_byte = wdata_q[8*wsel +: 8];
    end
  end

  always_comb begin
    if (frm_page_q)          last_byte = (pos_q == 3'd2);
    else if (we_q)           last_byte = (pos_q == nb_q + 3'd1);
    else if (pos_q < 3'd2)   last_byte = 1'b0;
    else if (!acked_q)       last_byte = !sh_rx[0] && (poll_q == POLL_LAST);
    else                     last_byte = (dcnt_q == 2'(nb_q - 3'd1));
  end

  always_comb begin
    state_d  = state_q;
    sh_start = 1'b0;
    case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_SETUP;
      ST_SETUP: if (tick) begin state_d = ST_SHIFT; sh_start = 1'b1; end
      ST_SHIFT: if (sh_done) begin
                  if (last_byte) state_d = ST_HOLD;
                  else           sh_start = 1'b1;
                end
      ST_HOLD:  if (tick) state_d = ST_GAP;
      ST_GAP:   if (tick) state_d = frm_page_q ? ST_SETUP : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign restart = (state_d != state_q) || sh_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      pos_q      <= '0;
      frm_page_q <= 1'b0;
      we_q       <= 1'b0;
      page_q     <= '0;
      off_q      <= '0;
      nb_q       <= 3'd1;
      wdata_q    <= '0;
      pvalid_q   <= 1'b0;
      pcache_q   <= '0;
      acked_q    <= 1'b0;
      dcnt_q     <= '0;
      poll_q     <= '0;
      rbuf_q     <= '0;
      err_q      <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      rdata_o    <= '0;
    end else begin
      state_q <= state_d;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      if (state_q == ST_IDLE && req_i) begin
        we_q       <= we_i;
        page_q     <= page_i;
        off_q      <= offset_i;
        nb_q       <= size_bytes(len_i);
        wdata_q    <= wdata_i;
        frm_page_q <= page_miss;
        acked_q    <= 1'b0;
        dcnt_q     <= '0;
        poll_q     <= '0;
        rbuf_q     <= '0;
        err_q      <= 1'b0;
        if (page_miss) begin
          pvalid_q <= 1'b1;
          pcache_q <= page_i;
        end
      end
      if (sh_start) pos_q <= tx_idx;
      if (state_q == ST_SHIFT && sh_done && !frm_page_q && !we_q && pos_q >= 3'd2) begin
        if (!acked_q) begin
          if (sh_rx[0]) acked_q <= 1'b1;
          else begin
            poll_q <= poll_q + 1'b1;
            if (poll_q == POLL_LAST) err_q <= 1'b1;
          end
        end else begin
          rbuf_q[8*dcnt_q +: 8] <= sh_rx;
          dcnt_q <= dcnt_q + 1'b1;
        end
      end
      if (state_q == ST_GAP && tick) begin
        if (frm_page_q) frm_page_q <= 1'b0;
        else begin
          done_o  <= 1'b1;
          err_o   <= err_q;
          rdata_o <= err_q ? 32'h0 : rbuf_q;
        end
      end
    end
  end

  assign ready_o    = (state_q == ST_IDLE);
  assign spi_ss_n_o = !(state_q == ST_SETUP || state_q == ST_SHIFT || state_q == ST_HOLD);
endmodule

// File: rtl/spi_page_master_chk.sv
module spi_page_master_chk #(
  parameter int CLK_DIV = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic ready_o,
  input logic done_o,
  input logic err_o,
  input logic spi_ss_n_o,
  input logic spi_sck_o,
  input logic spi_mosi_o
);
  localparam int CW = $clog2(4 * CLK_DIV + 2);
  localparam logic [CW-1:0] TWO_U = CW'(2 * CLK_DIV);
  localparam logic [CW-1:0] ONE_U = CW'(CLK_DIV);

  logic [CW-1:0] hi_cnt, lo_cnt, ssh_cnt;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt  <= '0;
      lo_cnt  <= '0;
      ssh_cnt <= ONE_U;
    end else begin
      hi_cnt  <= spi_sck_o ? sat_inc(hi_cnt) : '0;
      lo_cnt  <= (!spi_sck_o && !spi_ss_n_o) ? sat_inc(lo_cnt) : '0;
      ssh_cnt <= spi_ss_n_o ? sat_inc(ssh_cnt) : '0;
    end
  end

  assert_idle_lines_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_ss_n_o |-> (!spi_sck_o && !spi_mosi_o));

  assert_mosi_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_sck_o && $past(spi_sck_o)) |-> $stable(spi_mosi_o));

  assert_sck_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_sck_o) |-> (hi_cnt == TWO_U));

  assert_sck_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_sck_o) |-> (lo_cnt >= TWO_U));

  assert_ss_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_ss_n_o) |-> (ssh_cnt >= ONE_U));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);

  assert_err_with_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
endmodule

bind spi_page_master spi_page_master_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ready_o(ready_o),
  .done_o(done_o), .err_o(err_o), .spi_ss_n_o(spi_ss_n_o),
  .spi_sck_o(spi_sck_o), .spi_mosi_o(spi_mosi_o)
);

// File: tb/spi_page_master_bench.sv
`timescale 1ns/1ps
module spi_page_master_bench;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] page = '0, off = '0;
  logic [1:0] len = '0;
  logic [31:0] wdata = '0, rdata;
  logic ready, done, err, ss_n, sck, mosi, miso = 1'b0;

  always #4 clk = ~clk;

  spi_page_master u_spi_page_master (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_o(ready), .we_i(we),
    .page_i(page), .offset_i(off), .len_i(len), .wdata_i(wdata),
    .rdata_o(rdata), .done_o(done), .err_o(err), .spi_ss_n_o(ss_n),
    .spi_sck_o(sck), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  // remote device model
  logic [7:0] smem [0:511];
  logic [7:0] exp_mem [0:511];
  logic [7:0] fb [0:127];
  logic [7:0] shreg = '0, spage = '0, last_cmd = '0;
  int nbit = 0, wait_n = 0, page_frames = 0, last_nb = 0;

  function automatic logic [8:0] sa(input logic [7:0] p, input logic [7:0] o);
    return {p[2:0], o[5:0]};
  endfunction

  function automatic logic [7:0] out_byte(input int k);
    int j;
    if (k < 2 || fb[0] != 8'h10) return 8'h00;
    j = k - 2;
    if (j < wait_n) return 8'hFE;
    if (j == wait_n) return 8'hC5;
    return smem[sa(spage, 8'(int'(fb[1]) + j - wait_n - 1))];
  endfunction

  always @(posedge sck or negedge ss_n) begin
    logic [7:0] ob;
    if (!sck) begin
      nbit = 0;
      miso = 1'b0;
    end else begin
      shreg = {shreg[6:0], mosi};
      nbit++;
      if (nbit % 8 == 0 && nbit <= 1024) fb[nbit/8 - 1] = shreg;
      ob = out_byte(nbit / 8);
      miso = ob[7 - nbit % 8];
    end
  end

  always @(posedge ss_n) begin
    if (nbit > 0) begin
      last_nb  = nbit / 8;
      last_cmd = fb[0];
      if (fb[0] == 8'h61 && fb[1] == 8'hFF && last_nb == 3) begin
        spage = fb[2];
        page_frames++;
      end else if (fb[0] == 8'h61) begin
        for (int i = 2; i < last_nb; i++) smem[sa(spage, 8'(int'(fb[1]) + i - 2))] = fb[i];
      end
    end
  end

  // SCK width monitor
  int hi_run = 0, lo_run = 0, min_hi = 1000, max_hi = 0, min_lo = 1000;
  always @(negedge clk) begin
    if (sck) begin
      hi_run++;
      if (lo_run > 0 && lo_run < min_lo) min_lo = lo_run;
      lo_run = 0;
    end else begin
      if (hi_run > 0) begin
        if (hi_run < min_hi) min_hi = hi_run;
        if (hi_run > max_hi) max_hi = hi_run;
      end
      hi_run = 0;
      if (!ss_n) lo_run++;
      else lo_run = 0;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      summary();
    end
  end

  bit exp_valid = 0;
  logic [7:0] exp_cache = '0;

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  task automatic run(input logic [7:0] pg, input logic [7:0] of, input logic [1:0] ln,
                     input bit w, input logic [31:0] wd, input int wn);
    int pf0, n;
    bit exp_pf, exp_to;
    logic [31:0] exp_rd;
    n = nbytes(ln);
    exp_pf = !exp_valid || (pg != exp_cache);
    exp_valid = 1; exp_cache = pg;
    exp_to = !w && (wn >= 100);
    exp_rd = '0;
    if (!w && !exp_to)
      for (int i = 0; i < n; i++) exp_rd[8*i +: 8] = exp_mem[sa(pg, 8'(of + i))];
    pf0 = page_frames;
    wait_n = wn;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; we = w; page = pg; off = of; len = ln; wdata = wd;
    @(negedge clk);
    req = 0;
    chk(!ready, "R8 ready drops after accept", 32'(ready), 32'd0);
    while (!done) @(negedge clk);
    chk((page_frames - pf0) == int'(exp_pf), "R4 page frame count", 32'(page_frames - pf0), 32'(exp_pf));
    chk(spage == pg, "R4 selected page", 32'(spage), 32'(pg));
    if (w) begin
      for (int i = 0; i < n; i++) exp_mem[sa(pg, 8'(of + i))] = wd[8*i +: 8];
      chk(last_cmd == 8'h61, "R2 R3 write command", 32'(last_cmd), 32'h61);
      chk(last_nb == 2 + n, "R3 write frame bytes", 32'(last_nb), 32'(2 + n));
      for (int i = 0; i < n; i++)
        chk(smem[sa(pg, 8'(of + i))] == wd[8*i +: 8], "R3 written byte LSB first",
            32'(smem[sa(pg, 8'(of + i))]), 32'(wd[8*i +: 8]));
      chk(err == 1'b0, "R8 no error on write", 32'(err), 32'd0);
    end else begin
      chk(last_cmd == 8'h10, "R2 R5 read command", 32'(last_cmd), 32'h10);
      chk(err == exp_to, "R6 error flag", 32'(err), 32'(exp_to));
      chk(rdata == exp_rd, exp_to ? "R6 rdata zero on timeout" : "R5 read data", rdata, exp_rd);
      if (exp_to) chk(last_nb == 102, "R6 polled bytes", 32'(last_nb), 32'd102);
    end
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", 32'(done), 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 512; i++) begin
      smem[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk(ss_n && !sck && !mosi, "R1 idle lines after reset", {29'd0, ss_n, sck, mosi}, 32'h4);
    chk(ready, "R1 ready after reset", 32'(ready), 32'd1);
    rst_n = 1;
    @(negedge clk);
    chk(ss_n && !sck && !mosi && ready, "R1 idle after release", {28'd0, ready, ss_n, sck, mosi}, 32'hC);

    run(8'd3, 8'd10, 2'd2, 1'b1, 32'hA1B2C3D4, 0);   // first access: page frame
    run(8'd3, 8'd10, 2'd2, 1'b0, 32'h0, 0);          // same page: none
    run(8'd3, 8'd11, 2'd1, 1'b0, 32'h0, 5);
    run(8'd5, 8'd0,  2'd0, 1'b1, 32'h0000_005A, 0);  // page change
    run(8'd5, 8'd0,  2'd0, 1'b0, 32'h0, 2);
    run(8'd5, 8'd20, 2'd3, 1'b1, 32'h1122_3344, 1);  // code 3 = four bytes
    run(8'd5, 8'd20, 2'd3, 1'b0, 32'h0, 3);
    run(8'd3, 8'd30, 2'd1, 1'b0, 32'h0, 99);         // marker on last poll
    run(8'd3, 8'd30, 2'd1, 1'b0, 32'h0, 100);        // timeout
    run(8'd3, 8'd30, 2'd1, 1'b0, 32'h0, 0);          // recovers after timeout

    for (int t = 0; t < 30; t++)
      run(8'($urandom % 4), 8'($urandom % 60), 2'($urandom % 4), 1'($urandom % 2),
          $urandom, int'($urandom % 6));

    chk(max_hi == 2 * DIV && min_hi == 2 * DIV, "R7 SCK high width", 32'(min_hi), 32'(2 * DIV));
    chk(min_lo >= 2 * DIV, "R7 SCK low width in frame", 32'(min_lo), 32'(2 * DIV));
    chk(ss_n && !sck && !mosi, "R1 idle at end", {29'd0, ss_n, sck, mosi}, 32'h4);

    finished = 1;
    summary();
  end
endmodule